// File: doc/BRIEF.md
# Oscillator Path Swap Controller

Two voltage-to-frequency oscillators that carry the two halves of a differential measurement never match exactly. This block removes the effect of that mismatch by exchanging the two measurement threads between the oscillators at regular intervals. One swap select drives four multiplexers. The two on the input side decide which thread's code each oscillator receives. The two on the output side send each oscillator's pulse stream back to the counter of the thread it is serving at that moment. Averaged over a full exchange cycle, each thread then sees the mean gain of the two oscillators.

The swap timing comes from the same summed pulse count that produces the adaptive sampling clock. The block samples the bit one position below the sampling bit, which is bit m−1 of the sum. It cleans that bit with a three-tap majority vote and toggles a flip-flop on every rising edge of the voted level. The select therefore holds each level for the same number of summed counts, and the two oscillators' frequencies do not affect the split. The level of the sampling clock itself would not serve here, because mismatch moves its duty cycle away from one half. The oscillators, the counters and the summing adder lie outside this block.

Top module: `osc_swap_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the swap select is 0, both routed codes are 0 and both routed pulse outputs are 0.
- R2: With the three-tap vote enabled, a level on the bit m−1 input that lasts one sampled cycle and is surrounded by the opposite level does not change the swap select.
- R3: Each rising edge of the voted bit m−1 toggles the swap select exactly once. The new value appears on the third clock edge, counting the first edge that samples the input high, when the input stays high for at least two samples.
- R4: When the summed count advances by one every clock, each level of the swap select lasts exactly 2^m clocks, where bit m is the sampling-clock bit.
- R5: With the swap select at 0, oscillator A receives thread 1's code and oscillator B receives thread 2's code. With the select at 1 the two codes are exchanged. The routed codes are registered and reflect the inputs and the select value held in the previous cycle.
- R6: With the swap select at 0, thread 1's pulse output carries oscillator A's pulses and thread 2's carries oscillator B's. With the select at 1 they are exchanged. Routing uses the same registered select and the same one-cycle delay as R5.
- R7: Every pulse that arrives on an oscillator input appears on exactly one thread output one cycle later, including in the cycle in which the select changes. No pulse is duplicated or lost.
- R8: A falling edge of the voted bit m−1 leaves the swap select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tap_i | input | 1 | Bit m−1 of the summed pulse count |
| thr1_code_i | input | CODE_W | Control code of measurement thread 1 |
| thr2_code_i | input | CODE_W | Control code of measurement thread 2 |
| osca_pulse_i | input | LANES | Pulse stream from oscillator A |
| oscb_pulse_i | input | LANES | Pulse stream from oscillator B |
| swap_sel_o | output | 1 | Current swap select (0 = straight, 1 = crossed) |
| osca_code_o | output | CODE_W | Code routed to oscillator A |
| oscb_code_o | output | CODE_W | Code routed to oscillator B |
| thr1_pulse_o | output | LANES | Pulses routed to thread 1's counter |
| thr2_pulse_o | output | LANES | Pulses routed to thread 2's counter |

## Verification
The bench builds the block with an 8-bit code, one pulse lane, the three-tap vote enabled and a sampling bit of m = 3. Each select level then lasts only eight clocks, so a free-running ramp covers many complete exchange cycles and checks every swap boundary, including pulses that arrive exactly at a change. Driving the tap input by hand reaches the single-sample glitch, a long high level followed by its falling edge, and the three-edge toggle latency, all within a few dozen cycles.

// File: rtl/oscswap_pkg.sv
`timescale 1ns/1ps
package oscswap_pkg;

   typedef enum logic {
      PATH_STRAIGHT = 1'b0,
      PATH_CROSSED  = 1'b1
   } path_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/swp_tap_voter.sv
`timescale 1ns/1ps
module swp_tap_voter #(
   parameter int TAPS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic voted_o
);
   import oscswap_pkg::*;

   generate
      if (TAPS != 1 && TAPS != 3) begin : g_bad_taps
         $error("swp_tap_voter: TAPS must be 1 or 3");
      end
   endgenerate

   logic [TAPS-1:0] taps_q;

   generate
      if (TAPS == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taps_q <= '0;
            else        taps_q <= lvl_i;
         end
         assign voted_o = taps_q[0];
      end else begin : g_vote
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taps_q <= '0;
            else        taps_q <= {taps_q[TAPS-2:0], lvl_i};
         end
         assign voted_o = maj3(taps_q[0], taps_q[1], taps_q[TAPS-1]);

         // R2: a rise of the voted level needs the input high on two samples
         a_r2_vote_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(voted_o) |-> ($past(lvl_i) && ($past(lvl_i, 2) || $past(lvl_i, 3))));
      end
   endgenerate

endmodule

// File: rtl/swp_half_divider.sv
`timescale 1ns/1ps
module swp_half_divider (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic sel_o
);
   import oscswap_pkg::*;

   logic  prev_q;
   path_e path_q;
   logic  rise;

   assign rise = lvl_i & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         path_q <= PATH_STRAIGHT;
      end else begin
         prev_q <= lvl_i;
         if (rise) path_q <= (path_q == PATH_STRAIGHT) ? PATH_CROSSED : PATH_STRAIGHT;
      end
   end

   assign sel_o = path_q;

   // R1: select held at straight routing during reset
   a_r1_sel_reset: assert property (@(posedge clk) !rst_n |-> (sel_o == 1'b0));

   // R3: a voted rise flips the select on the following edge
   a_r3_rise_flips: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lvl_i) |=> $changed(sel_o));

   // R3: the select never changes on two edges in a row
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(sel_o) |=> $stable(sel_o));

   // R8: a voted fall leaves the select alone
   a_r8_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lvl_i) |=> $stable(sel_o));

endmodule

// File: rtl/swp_xbar.sv
`timescale 1ns/1ps
module swp_xbar #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] a_o,
   output logic [W-1:0] b_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("swp_xbar: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_o <= '0;
         b_o <= '0;
      end else if (sel_i) begin
         a_o <= b_i;
         b_o <= a_i;
      end else begin
         a_o <= a_i;
         b_o <= b_i;
      end
   end

   // R1: outputs cleared in reset
   a_r1_xbar_reset: assert property (@(posedge clk) !rst_n |-> (a_o == '0 && b_o == '0));

   // R7: outputs are always a permutation of the previous inputs
   a_r7_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |->
         ((a_o == $past(a_i) && b_o == $past(b_i)) ||
          (a_o == $past(b_i) && b_o == $past(a_i))));

endmodule

// File: rtl/osc_swap_ctrl.sv
`timescale 1ns/1ps
module osc_swap_ctrl #(
   parameter int CODE_W    = 14,
   parameter int LANES     = 1,
   parameter int VOTE_TAPS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tap_i,
   input  logic [CODE_W-1:0] thr1_code_i,
   input  logic [CODE_W-1:0] thr2_code_i,
   input  logic [LANES-1:0]  osca_pulse_i,
   input  logic [LANES-1:0]  oscb_pulse_i,
   output logic              swap_sel_o,
   output logic [CODE_W-1:0] osca_code_o,
   output logic [CODE_W-1:0] oscb_code_o,
   output logic [LANES-1:0]  thr1_pulse_o,
   output logic [LANES-1:0]  thr2_pulse_o
);

   generate
      if (CODE_W < 1 || LANES < 1) begin : g_bad_width
         $error("osc_swap_ctrl: CODE_W and LANES must be positive");
      end
   endgenerate

   logic voted;
   logic sel;

   swp_tap_voter #(.TAPS(VOTE_TAPS)) u_voter (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (half_tap_i),
      .voted_o (voted)
   );

   swp_half_divider u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (voted),
      .sel_o (sel)
   );

   // input side: thread codes to oscillators
   swp_xbar #(.W(CODE_W)) u_code_mux (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (sel),
      .a_i   (thr1_code_i),
      .b_i   (thr2_code_i),
      .a_o   (osca_code_o),
      .b_o   (oscb_code_o)
   );

   // output side: oscillator pulses back to thread counters
   swp_xbar #(.W(LANES)) u_pulse_mux (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_i (sel),
      .a_i   (osca_pulse_i),
      .b_i   (oscb_pulse_i),
      .a_o   (thr1_pulse_o),
      .b_o   (thr2_pulse_o)
   );

   assign swap_sel_o = sel;

   // R7: pulse count conserved across the routing stage
   a_r7_pulse_conserve: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |->
         ($countones({thr1_pulse_o, thr2_pulse_o}) ==
          $past($countones({osca_pulse_i, oscb_pulse_i}))));

endmodule

// File: tb/osc_swap_ctrl_tb.sv
`timescale 1ns/1ps
module osc_swap_ctrl_tb;
   localparam int CODE_W = 8;
   localparam int LANES  = 1;
   localparam int BIT_M  = 3;
   localparam int RUN    = 1 << BIT_M;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic half_tap = 1'b0;
   logic [CODE_W-1:0] t1c = '0, t2c = '0;
   logic [LANES-1:0] pa = '0, pb = '0;
   logic sel;
   logic [CODE_W-1:0] oac, obc;
   logic [LANES-1:0] p1, p2;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #4 clk = ~clk;

   osc_swap_ctrl #(.CODE_W(CODE_W), .LANES(LANES), .VOTE_TAPS(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .half_tap_i(half_tap),
      .thr1_code_i(t1c), .thr2_code_i(t2c),
      .osca_pulse_i(pa), .oscb_pulse_i(pb),
      .swap_sel_o(sel), .osca_code_o(oac), .oscb_code_o(obc),
      .thr1_pulse_o(p1), .thr2_pulse_o(p2)
   );

   // behavioural reference
   int hist[$];
   bit m_vote, m_prev, m_sel;
   logic [CODE_W-1:0] e_oac, e_obc;
   logic [LANES-1:0]  e_p1, e_p2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = {};
         m_vote = 0; m_prev = 0; m_sel = 0;
         e_oac = '0; e_obc = '0; e_p1 = '0; e_p2 = '0;
      end else begin
         bit nsel;
         int ones;
         nsel = m_sel ^ (m_vote & !m_prev);
         if (m_sel) begin
            e_oac = t2c; e_obc = t1c; e_p1 = pb; e_p2 = pa;
         end else begin
            e_oac = t1c; e_obc = t2c; e_p1 = pa; e_p2 = pb;
         end
         m_sel = nsel;
         hist.push_back(int'(half_tap));
         if (hist.size() > 3) void'(hist.pop_front());
         ones = 0;
         foreach (hist[k]) ones += hist[k];
         m_prev = m_vote;
         m_vote = (ones >= 2);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // run-length tracking of the swap select
   bit track_runs = 0;
   int run_len = 0;
   int runs_seen = 0;
   bit last_sel = 0;

   task automatic compare_all();
      chk("R3 swap_sel", int'(sel), int'(m_sel));
      chk("R5 osca_code", int'(oac), int'(e_oac));
      chk("R5 oscb_code", int'(obc), int'(e_obc));
      chk("R6 thr1_pulse", int'(p1), int'(e_p1));
      chk("R6 thr2_pulse", int'(p2), int'(e_p2));
      chk("R7 pulse count", $countones({p1, p2}), $countones({e_p1, e_p2}));
      if (track_runs) begin
         if (sel != last_sel) begin
            runs_seen++;
            if (runs_seen > 2) chk("R4 select level length", run_len, RUN);
            run_len = 1;
         end else begin
            run_len++;
         end
      end
      last_sel = sel;
   endtask

   task automatic tick(input logic bv);
      @(negedge clk);
      compare_all();
      half_tap = bv;
      t1c = CODE_W'($urandom);
      t2c = CODE_W'($urandom);
      pa  = LANES'($urandom);
      pb  = LANES'($urandom);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      bit held;
      // R1: reset state with busy inputs
      t1c = 8'hA5; t2c = 8'h3C; pa = 1'b1; pb = 1'b1; half_tap = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 sel in reset", int'(sel), 0);
      chk("R1 osca_code in reset", int'(oac), 0);
      chk("R1 oscb_code in reset", int'(obc), 0);
      chk("R1 pulses in reset", int'({p1, p2}), 0);
      half_tap = 1'b0; pa = '0; pb = '0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sel after release", int'(sel), 0);
      chk("R1 outputs after release", int'({p1, p2}), 0);

      // R4/R5/R6/R7: free-running ramp of the summed count
      track_runs = 1;
      last_sel = sel;
      for (int i = 0; i < 240; i++) tick(1'((i >> (BIT_M - 1)) & 1));
      track_runs = 0;

      // R2: single-sample glitch is rejected
      for (int i = 0; i < 8; i++) tick(1'b0);
      @(negedge clk); held = sel;
      half_tap = 1'b1;
      @(negedge clk); compare_all(); half_tap = 1'b0;
      for (int i = 0; i < 6; i++) tick(1'b0);
      @(negedge clk); compare_all();
      chk("R2 glitch leaves select", int'(sel), int'(held));

      // R3: two-sample high toggles on the third edge
      held = sel;
      half_tap = 1'b1;
      @(negedge clk); compare_all();
      chk("R3 no change after 1 edge", int'(sel), int'(held));
      @(negedge clk); compare_all();
      chk("R3 no change after 2 edges", int'(sel), int'(held));
      @(negedge clk); compare_all();
      chk("R3 toggled after 3 edges", int'(sel), int'(!held));

      // R8: long high then fall does nothing further
      for (int i = 0; i < 6; i++) tick(1'b1);
      @(negedge clk); held = sel;
      for (int i = 0; i < 8; i++) tick(1'b0);
      @(negedge clk); compare_all();
      chk("R8 fall leaves select", int'(sel), int'(held));

      // second ramp with fresh random traffic
      for (int i = 0; i < 64; i++) tick(1'((i >> (BIT_M - 1)) & 1));

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule